// File: doc/BRIEF.md
# One-Shot Programmable Down Timer

This block is an 8-bit timer that counts down once and then stops. Software presets it with a full byte or with either 4-bit half on its own. It then arms it by writing a mode word with the start bit set. While armed, an internal prescaler issues one count enable every `DIV_FAST` or every `DIV_SLOW` clock cycles, as a clock-select bit in the same mode word chooses. Each enable lowers the count by one.

When a decrement takes the count from 00H past zero, the counter wraps to FFH and holds there. The start bit drops and an underflow flag is raised. The flag stays set until the next start. It feeds two separately enabled registered requests: one to the interrupt logic and one to the hold-mode release logic.

Any preset write stops a running count and drops the start bit. A preset write that lands in the same cycle as a count enable takes priority over that enable.

Top module: `oneshot_down_timer`

## Requirements
- R1: After a synchronous reset, the count is 00H, the underflow flag and both requests are 0, the timer is idle, and the fast count rate is selected.
- R2: A cycle with `ld_byte` high loads `ld_data` into the count at that clock edge.
- R3: `ld_nib` bit 0 replaces count bits 3:0 with `ld_data[3:0]`, and `ld_nib` bit 1 replaces count bits 7:4 with `ld_data[3:0]`. The half that is not written keeps its value.
- R4: A mode write with bit 3 = 1 and bit 0 = 0 clears the flag, restarts the prescaler, and starts counting. The count drops by one every `DIV_FAST` cycles. The first drop comes `DIV_FAST` cycles after the write edge.
- R5: A mode write with bit 3 = 1 and bit 0 = 1 counts at one decrement every `DIV_SLOW` cycles. The first drop comes `DIV_SLOW` cycles after the write edge.
- R6: The decrement from 00H sets the count to FFH, sets the flag and stops the timer. From a start value V, this happens (V+1)·DIV cycles after the start edge. The count then stays at FFH.
- R7: A byte or nibble load while the timer is running stops it. The count then keeps the loaded value, and the load does not change the flag.
- R8: A load in the same cycle as the count enable that would underflow wins. The count takes the loaded value, the flag stays 0, and the timer stops.
- R9: `irq_req` equals the flag ANDed with `irq_en`, registered one cycle later.
- R10: `hold_rel` equals the flag ANDed with `hold_en`, registered one cycle later.
- R11: A mode write with bit 3 = 0 stops a running count, and the count holds its value.
- R12: Once set, the flag stays 1 through idle cycles and loads until the next start write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_byte | input | 1 | Full-byte preset strobe |
| ld_nib | input | 2 | Nibble preset strobes (bit 0 low half, bit 1 high half) |
| ld_data | input | 8 | Preset data; nibble writes use bits 3:0 |
| mode_wr | input | 1 | Mode word write strobe |
| mode_data | input | 4 | Mode word: bit 3 start, bit 0 slow clock select |
| irq_en | input | 1 | Interrupt request enable |
| hold_en | input | 1 | Hold-release request enable |
| count_q | output | 8 | Current count |
| evt_flag | output | 1 | Underflow flag |
| irq_req | output | 1 | Interrupt request |
| hold_rel | output | 1 | Hold-release request |

## Verification
A preset write and the final count enable can fall in the same cycle, and then the preset must win. The bench sets up this collision by loading 00H and starting at the fast rate. It then raises `ld_byte` so that the strobe is present at exactly the edge `DIV_FAST` cycles after the start edge, which is the edge that would underflow. The result is judged on the next sample and again many cycles later: the count must hold the new preset, the flag must stay clear, and the timer must not count again.

// File: rtl/ost_pkg.sv
package ost_pkg;
  localparam int CNT_W    = 8;
  localparam int NIB_W    = 4;
  localparam int NIBS     = CNT_W / NIB_W;
  localparam int MODE_W   = 4;
  localparam int START_B  = 3;
  localparam int CSEL_B   = 0;
endpackage

// File: rtl/ost_mode_reg.sv
module ost_mode_reg
  import ost_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_data,
  input  logic              any_load,
  input  logic              underflow,
  output logic              start_pulse,
  output logic              run_q,
  output logic              csel_q
);
  assign start_pulse = mode_wr && mode_data[START_B] && !any_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
    end else if (any_load) begin
      run_q <= 1'b0;
    end else if (mode_wr) begin
      run_q <= mode_data[START_B];
    end else if (underflow) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csel_q <= 1'b0;
    end else if (mode_wr) begin
      csel_q <= mode_data[CSEL_B];
    end
  end

  // R7
  load_stops_chk: assert property (@(posedge clk) disable iff (rst)
    any_load |=> !run_q);

  // R6
  underflow_stops_chk: assert property (@(posedge clk) disable iff (rst)
    (underflow && !mode_wr) |=> !run_q);

  // R11
  stop_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && !mode_data[START_B]) |=> !run_q);
endmodule

// File: rtl/ost_prescaler.sv
module ost_prescaler #(
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic csel,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV_SLOW > DIV_FAST) ? $clog2(DIV_SLOW) : $clog2(DIV_FAST);
  localparam logic [PW-1:0] FAST_LAST = PW'(DIV_FAST - 1);
  localparam logic [PW-1:0] SLOW_LAST = PW'(DIV_SLOW - 1);

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] last;
  logic          at_last;

  assign last    = csel ? SLOW_LAST : FAST_LAST;
  assign at_last = (pcnt_q >= last);
  assign tick    = run && !restart && at_last;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      pcnt_q <= '0;
    end else if (at_last) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  initial begin
    if (DIV_FAST < 2 || DIV_SLOW < 2) begin
      $error("prescaler divisors must be at least 2");
    end
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/ost_counter.sv
module ost_counter
  import ost_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_byte,
  input  logic [NIBS-1:0]  ld_nib,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             tick,
  output logic             any_load,
  output logic             underflow,
  output logic [CNT_W-1:0] count_q
);
  logic [CNT_W-1:0] nib_mix;

  generate
    for (genvar g = 0; g < NIBS; g++) begin : g_lane
      assign nib_mix[g*NIB_W +: NIB_W] =
        ld_nib[g] ? ld_data[NIB_W-1:0] : count_q[g*NIB_W +: NIB_W];
    end
  endgenerate

  assign any_load  = ld_byte || (|ld_nib);
  assign underflow = tick && !any_load && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (ld_byte) begin
      count_q <= ld_data;
    end else if (|ld_nib) begin
      count_q <= nib_mix;
    end else if (tick) begin
      count_q <= count_q - 1'b1;
    end
  end

  // R4
  decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !any_load) |=> count_q == CNT_W'($past(count_q) - 1'b1));

  // R11
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !any_load) |=> $stable(count_q));

  // R2
  byte_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_byte |=> count_q == $past(ld_data));
endmodule

// File: rtl/ost_event.sv
module ost_event (
  input  logic clk,
  input  logic rst,
  input  logic start_pulse,
  input  logic underflow,
  input  logic irq_en,
  input  logic hold_en,
  output logic evt_q,
  output logic irq_q,
  output logic hold_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= 1'b0;
    end else if (start_pulse) begin
      evt_q <= 1'b0;
    end else if (underflow) begin
      evt_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      irq_q  <= evt_q && irq_en;
      hold_q <= evt_q && hold_en;
    end
  end

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (underflow && !start_pulse) |=> evt_q);

  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_q && !start_pulse) |=> evt_q);

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !evt_q);
endmodule

// File: rtl/oneshot_down_timer.sv
module oneshot_down_timer
  import ost_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_byte,
  input  logic [NIBS-1:0]   ld_nib,
  input  logic [CNT_W-1:0]  ld_data,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_data,
  input  logic              irq_en,
  input  logic              hold_en,
  output logic [CNT_W-1:0]  count_q,
  output logic              evt_flag,
  output logic              irq_req,
  output logic              hold_rel
);
  logic any_load;
  logic underflow;
  logic start_pulse;
  logic run_q;
  logic csel_q;
  logic tick;

  ost_mode_reg u_mode (
    .clk         (clk),
    .rst         (rst),
    .mode_wr     (mode_wr),
    .mode_data   (mode_data),
    .any_load    (any_load),
    .underflow   (underflow),
    .start_pulse (start_pulse),
    .run_q       (run_q),
    .csel_q      (csel_q)
  );

  ost_prescaler #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW)
  ) u_presc (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .csel    (csel_q),
    .restart (start_pulse),
    .tick    (tick)
  );

  ost_counter u_cnt (
    .clk       (clk),
    .rst       (rst),
    .ld_byte   (ld_byte),
    .ld_nib    (ld_nib),
    .ld_data   (ld_data),
    .tick      (tick),
    .any_load  (any_load),
    .underflow (underflow),
    .count_q   (count_q)
  );

  ost_event u_evt (
    .clk         (clk),
    .rst         (rst),
    .start_pulse (start_pulse),
    .underflow   (underflow),
    .irq_en      (irq_en),
    .hold_en     (hold_en),
    .evt_q       (evt_flag),
    .irq_q       (irq_req),
    .hold_q      (hold_rel)
  );

  // R8
  collision_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && any_load && !evt_flag && !start_pulse) |=> !evt_flag);

  // R6
  wrap_value_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |=> count_q == '1);

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (underflow && !start_pulse && !mode_wr && irq_en) |=> ##1 irq_req);
endmodule

// File: tb/test_oneshot_down_timer.sv
module test_oneshot_down_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DF = 4;
  localparam int DS = 1024;

  logic       clk = 1'b0;
  logic       rst;
  logic       ld_byte;
  logic [1:0] ld_nib;
  logic [7:0] ld_data;
  logic       mode_wr;
  logic [3:0] mode_data;
  logic       irq_en;
  logic       hold_en;
  logic [7:0] count_q;
  logic       evt_flag;
  logic       irq_req;
  logic       hold_rel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_down_timer #(.DIV_FAST(DF), .DIV_SLOW(DS)) i_oneshot_down_timer (
    .clk(clk), .rst(rst), .ld_byte(ld_byte), .ld_nib(ld_nib), .ld_data(ld_data),
    .mode_wr(mode_wr), .mode_data(mode_data), .irq_en(irq_en), .hold_en(hold_en),
    .count_q(count_q), .evt_flag(evt_flag), .irq_req(irq_req), .hold_rel(hold_rel)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_byte(input logic [7:0] v);
    ld_byte = 1'b1; ld_data = v;
    @(negedge clk);
    ld_byte = 1'b0;
  endtask

  task automatic load_nib(input logic [1:0] which, input logic [3:0] v);
    ld_nib = which; ld_data = {4'h0, v};
    @(negedge clk);
    ld_nib = 2'b00;
  endtask

  task automatic write_mode(input logic [3:0] v);
    mode_wr = 1'b1; mode_data = v;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "count", count_q, 8'h00);
    chk("R1", "flag", evt_flag, 0);
    chk("R1", "irq", irq_req, 0);
    chk("R1", "hold", hold_rel, 0);
    wait_cyc(20);
    chk("R1", "idle count", count_q, 8'h00);
  endtask

  task automatic t_loads;
    load_byte(8'hA5);
    chk("R2", "byte load", count_q, 8'hA5);
    load_nib(2'b01, 4'h3);
    chk("R3", "low nibble", count_q, 8'hA3);
    load_nib(2'b10, 4'hC);
    chk("R3", "high nibble", count_q, 8'hC3);
    load_nib(2'b11, 4'h6);
    chk("R3", "both nibbles", count_q, 8'h66);
  endtask

  task automatic t_fast_run;
    irq_en = 1'b0; hold_en = 1'b0;
    load_byte(8'h03);
    write_mode(4'b1000);
    chk("R4", "start value", count_q, 8'h03);
    wait_cyc(DF - 1);
    chk("R4", "before first tick", count_q, 8'h03);
    wait_cyc(1);
    chk("R4", "first tick", count_q, 8'h02);
    wait_cyc(2*DF);
    chk("R4", "third value", count_q, 8'h00);
    chk("R6", "flag before wrap", evt_flag, 0);
    wait_cyc(DF);
    chk("R6", "wrap value", count_q, 8'hFF);
    chk("R6", "flag set", evt_flag, 1);
    wait_cyc(30);
    chk("R6", "holds FF", count_q, 8'hFF);
    chk("R9", "irq masked", irq_req, 0);
    chk("R10", "hold masked", hold_rel, 0);
  endtask

  task automatic t_requests;
    irq_en = 1'b1; hold_en = 1'b0;
    load_byte(8'h00);
    write_mode(4'b1000);
    chk("R4", "start clears flag", evt_flag, 0);
    wait_cyc(DF);
    chk("R6", "flag from 00", evt_flag, 1);
    chk("R9", "irq lags flag", irq_req, 0);
    wait_cyc(1);
    chk("R9", "irq raised", irq_req, 1);
    chk("R10", "hold still masked", hold_rel, 0);
    hold_en = 1'b1;
    wait_cyc(1);
    chk("R10", "hold raised", hold_rel, 1);
    wait_cyc(10);
    chk("R12", "flag persists", evt_flag, 1);
    load_byte(8'h40);
    chk("R12", "flag kept over load", evt_flag, 1);
    chk("R7", "load keeps flag", evt_flag, 1);
    write_mode(4'b1000);
    chk("R12", "start clears flag", evt_flag, 0);
    wait_cyc(1);
    chk("R9", "irq dropped", irq_req, 0);
    chk("R10", "hold dropped", hold_rel, 0);
    write_mode(4'b0000);
    irq_en = 1'b0; hold_en = 1'b0;
  endtask

  task automatic t_load_halt;
    load_byte(8'h20);
    write_mode(4'b1000);
    wait_cyc(2*DF);
    chk("R4", "two ticks", count_q, 8'h1E);
    load_nib(2'b01, 4'h7);
    chk("R7", "loaded while running", count_q, 8'h17);
    wait_cyc(5*DF);
    chk("R7", "halted after load", count_q, 8'h17);
  endtask

  task automatic t_stop_bit;
    load_byte(8'h10);
    write_mode(4'b1000);
    wait_cyc(DF);
    chk("R4", "one tick", count_q, 8'h0F);
    write_mode(4'b0000);
    wait_cyc(4*DF);
    chk("R11", "stopped by mode write", count_q, 8'h0F);
  endtask

  task automatic t_collision;
    load_byte(8'h00);
    write_mode(4'b1000);
    wait_cyc(DF - 1);
    load_byte(8'h55);
    chk("R8", "load wins", count_q, 8'h55);
    chk("R8", "no flag", evt_flag, 0);
    wait_cyc(5*DF);
    chk("R8", "stays halted", count_q, 8'h55);
    chk("R8", "flag still clear", evt_flag, 0);
  endtask

  task automatic t_slow;
    load_byte(8'h02);
    write_mode(4'b1001);
    wait_cyc(DS - 1);
    chk("R5", "before slow tick", count_q, 8'h02);
    wait_cyc(1);
    chk("R5", "first slow tick", count_q, 8'h01);
    wait_cyc(2*DS);
    chk("R5", "slow wrap", count_q, 8'hFF);
    chk("R6", "slow flag", evt_flag, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; ld_byte = 1'b0; ld_nib = 2'b00; ld_data = 8'h00;
    mode_wr = 1'b0; mode_data = 4'h0; irq_en = 1'b0; hold_en = 1'b0;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_loads();
    t_fast_run();
    t_requests();
    t_load_halt();
    t_stop_bit();
    t_collision();
    t_slow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule